// File: doc/BRIEF.md
# Integer Load Merge Unit

This unit forms the new contents of a 48-bit integer destination register when a fixed-point operand is loaded into it. The operand is 8, 12, 24, 36 or 48 bits wide. It comes either from a 48-bit memory data field or from a source register. The operand always lands in the low bits of the destination. The bits above it are filled in one of three ways: copies of the operand's sign bit, zeros, or the old destination contents.

The two sources supply a narrow operand from opposite ends. A memory operand begins at the addressed 12-bit cell, so it sits in the most significant bits of the memory field. A register operand is the low part of the source register. The unit registers its result once. A request presented with `in_valid` high appears on `dst_new` one clock later. While no request is presented, the result holds.

Top module: `int_load_merge`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0 and `dst_new` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. After a clock edge with `in_valid` low, `dst_new` keeps its previous value.
- R3: With `from_mem` = 0, the operand of width w is `src_reg[w-1:0]`, and `mem_field` has no effect.
- R4: With `from_mem` = 1, the operand of width w is `mem_field[47:48-w]`, and `src_reg` has no effect. A byte is therefore `mem_field[47:40]`.
- R5: With `mode` = 0 (signed load), `dst_new[w-1:0]` is the operand and every bit above holds the operand's top bit.
- R6: With `mode` = 1 (unsigned load), `dst_new[w-1:0]` is the operand and every bit above is 0.
- R7: With `mode` = 2 (insert), `dst_new[w-1:0]` is the operand and `dst_new[47:w]` equals `dst_old[47:w]` of the same request.
- R8: The `size` codes are 0 = 8, 1 = 12, 2 = 24, 3 = 36 and 4 = 48 bits. For size 4, `dst_new` equals the whole selected source in every mode.
- R9: The unused `size` codes 5, 6 and 7 behave as code 4. The unused `mode` code 3 behaves as code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| from_mem | input | 1 | 1: operand from memory field, 0: from source register |
| size | input | 3 | Operand size code |
| mode | input | 2 | Fill mode code |
| mem_field | input | 48 | Memory data, addressed cell in the top bits |
| src_reg | input | 48 | Source register value |
| dst_old | input | 48 | Current destination register value |
| out_valid | output | 1 | Result valid |
| dst_new | output | 48 | New destination register value |

## Verification
The hardest cases to reach have two properties at once. The top bit of the operand differs from the neighbouring bits. The unselected source carries a contrasting pattern. Only then does a wrong slice end or a wrong fill show up. The directed sweep covers every source, size and mode, including the unused codes. It uses operands whose sign bit sits right next to opposite-valued bits, and it fills the other source and `dst_old` with a complementary pattern. Random requests with idle gaps follow, and they exercise the hold behaviour.

// File: rtl/int_load_merge.sv
module int_load_merge #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         from_mem,
  input  logic [2:0]   size,
  input  logic [1:0]   mode,
  input  logic [W-1:0] mem_field,
  input  logic [W-1:0] src_reg,
  input  logic [W-1:0] dst_old,
  output logic         out_valid,
  output logic [W-1:0] dst_new
);
  localparam int WB = 8;
  localparam int WS = 12;
  localparam int WI = 24;
  localparam int WA = 36;
  localparam int SW = $clog2(W + 1);

  logic [SW-1:0] width;
  logic [W-1:0]  mask, op, fill, merged;
  logic          sgn;

  always_comb begin
    case (size)
      3'd0:    width = SW'(WB);
      3'd1:    width = SW'(WS);
      3'd2:    width = SW'(WI);
      3'd3:    width = SW'(WA);
      default: width = SW'(W);
    endcase
  end

  assign mask = ~({W{1'b1}} << width);
  assign op   = from_mem ? (mem_field >> (SW'(W) - width)) : (src_reg & mask);
  assign sgn  = op[width - SW'(1)];

  always_comb begin
    case (mode)
      2'd0:    fill = sgn ? ~mask : '0;
      2'd2:    fill = dst_old & ~mask;
      default: fill = '0;
    endcase
  end

  assign merged = op | fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_new <= merged;
    end
  end
endmodule

// File: rtl/int_load_merge_chk.sv
module int_load_merge_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         from_mem,
  input logic [2:0]   size,
  input logic [1:0]   mode,
  input logic [W-1:0] mem_field,
  input logic [W-1:0] src_reg,
  input logic [W-1:0] dst_old,
  input logic         out_valid,
  input logic [W-1:0] dst_new
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_new)));
  a_r5_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && size == 3'd0) |=>
      (dst_new[W-1:7] == '0 || dst_new[W-1:7] == '1));
  a_r6_int_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && size == 3'd2) |=> dst_new[W-1:24] == '0);
  a_r7_byte_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && size == 3'd0) |=> dst_new[W-1:8] == $past(dst_old[W-1:8]));
  a_r8_long_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 3'd4) |=> dst_new == $past(from_mem ? mem_field : src_reg));
  a_r4_mem_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && from_mem && size == 3'd0) |=> dst_new[7:0] == $past(mem_field[W-1:W-8]));
endmodule

bind int_load_merge int_load_merge_chk #(.W(W)) i_chk (.*);

// File: tb/test_int_load_merge.sv
module test_int_load_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        from_mem = 1'b0;
  logic [2:0]  size = '0;
  logic [1:0]  mode = '0;
  logic [47:0] mem_field = '0;
  logic [47:0] src_reg = '0;
  logic [47:0] dst_old = '0;
  logic        out_valid;
  logic [47:0] dst_new;

  int total = 0;
  int bad = 0;
  logic        exp_v = 1'b0;
  logic [47:0] exp_d = '0;
  string       exp_tag = "R1";

  always #4 clk = ~clk;

  int_load_merge i_int_load_merge (.*);

  function automatic logic [47:0] model(input bit mem, input int sz, input int md,
                                        input logic [47:0] mf, input logic [47:0] sr,
                                        input logic [47:0] old);
    int w;
    logic [47:0] r;
    logic s;
    case (sz)
      0: w = 8;
      1: w = 12;
      2: w = 24;
      3: w = 36;
      default: w = 48;
    endcase
    for (int i = 0; i < w; i++) r[i] = mem ? mf[48 - w + i] : sr[i];
    s = r[w-1];
    for (int i = w; i < 48; i++) r[i] = (md == 0) ? s : (md == 2) ? old[i] : 1'b0;
    return r;
  endfunction

  function automatic string tag_of(input bit mem, input int sz, input int md);
    string t;
    t = mem ? "R4" : "R3";
    if (sz >= 5 || md == 3) t = {t, " R9"};
    else if (sz == 4) t = {t, " R8"};
    else if (md == 0) t = {t, " R5"};
    else if (md == 1) t = {t, " R6"};
    else t = {t, " R7"};
    return t;
  endfunction

  task automatic check_now();
    total++;
    if (out_valid !== exp_v || dst_new !== exp_d) begin
      bad++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               exp_tag, out_valid, dst_new, exp_v, exp_d);
    end
  endtask

  task automatic step(input bit v, input bit mem, input int sz, input int md,
                      input logic [47:0] mf, input logic [47:0] sr, input logic [47:0] old);
    @(negedge clk);
    check_now();
    in_valid = v; from_mem = mem; size = 3'(sz); mode = 2'(md);
    mem_field = mf; src_reg = sr; dst_old = old;
    exp_v = v;
    if (v) begin
      exp_d = model(mem, sz, md, mf, sr, old);
      exp_tag = tag_of(mem, sz, md);
    end else exp_tag = "R2";
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: valid=%0b data=%h expected completion", out_valid, dst_new);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(); // R1 during reset
    rst_n = 1'b1;
    exp_tag = "R1";
    // directed sweep: R3 R4 R5 R6 R7 R8 R9
    for (int mem = 0; mem < 2; mem++)
      for (int sz = 0; sz < 8; sz++)
        for (int md = 0; md < 4; md++)
          for (int p = 0; p < 2; p++) begin
            logic [47:0] a;
            a = p ? 48'h8000_0800_8080 : 48'h7FFF_F7FF_7F7F;
            a = a ^ {48{mem[0]}};
            step(1'b1, mem[0], sz, md, mem ? a : ~a, mem ? ~a : a, 48'hA5A5_5A5A_C3C3 ^ {48{p[0]}});
          end
    step(1'b0, 1'b0, 0, 0, '1, '1, '1); // R2 hold
    step(1'b0, 1'b1, 4, 2, '0, '1, '0); // R2 hold
    for (int k = 0; k < 400; k++) begin
      logic [47:0] mf, sr, od;
      mf = {$urandom, $urandom} ;
      sr = {$urandom, $urandom};
      od = {$urandom, $urandom};
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 8, $urandom % 4, mf, sr, od);
    end
    step(1'b0, 1'b0, 0, 0, '0, '0, '0);
    @(negedge clk);
    check_now();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule